// File: doc/BRIEF.md
# Indirect-Access SDRAM Controller Register File

This block holds the control and status registers of a DDR SDRAM controller. A host reaches it through a pair of device-control registers. One device-control index holds a pointer into an internal offset space. A second index reads or writes whatever internal register that pointer selects. All other device-control indices fall outside the block.

Inside the offset space sit these registers: two error status words, an error address, a configuration word, a read-only status word, a refresh timer, a power-management timer, a timing word, four bank configuration words, an ECC configuration word and an ECC error word. Each writable register keeps only the bits its write mask allows.

Two configuration bits are reflected into the status word whenever they change. The ECC error word drives a level interrupt that tracks whether it holds an error. Reads are combinational while `acc_en` is high. Writes take effect at the next rising clock edge.

Top module: `sdram_csr_file`

## Requirements
- R1: Device-control index 0x10 is the pointer register. A write keeps the low 8 bits of the data. A read returns those 8 bits with upper bits zero. Index 0x11 reads or writes the internal register the pointer selects. Any other index reads 0, and a write to it changes nothing.
- R2: After reset the status word reads 0x80000000 and the power-management timer reads 0x07C00000. `ecc_irq` is low. The pointer and every other register read 0.
- R3: A configuration write (offset 0x20) that takes bit 31 from 0 to 1 clears status bit 31. One that takes bit 31 from 1 to 0 sets status bit 31.
- R4: A configuration write that changes bit 30 copies the new bit 30 into status bit 30.
- R5: The status word (offset 0x24) is read-only. A write to it leaves its value unchanged.
- R6: A write to the refresh timer (0x30) keeps bits in 0x3FF80000. A write to the timing word (0x80) keeps bits in 0x018FC01F. A write to ECC configuration (0x94) keeps bits in 0x00F00000.
- R7: A write to the power-management timer (0x34) stores (value & 0xF8000000) | 0x07C00000.
- R8: Bank configuration word k lives at offset 0x40 + 4k, for k = 0 to 3. A write keeps the bits in 0xFFDEE001 and touches only that bank's word.
- R9: The ECC error word (0x98) stores the full 32-bit value. `ecc_irq` rises when a nonzero value is written while the word holds zero. It falls when zero is written while the word is nonzero. In all other cases it holds.
- R10: Reading an offset that maps to no register returns 0. Writing one changes no register.
- R11: Error status 0 (0x00), error status 1 (0x08), error address (0x10) and configuration (0x20) store and return all 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Device-control access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 10 | Device-control index |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational, 0 when idle |
| ecc_irq | output | 1 | ECC error interrupt, level |

## Verification
A wrong pointer or a wrong decode shows up on the first data-index read after the write that set it. It surfaces as the wrong register's value, or as a nonzero value where zero is due. A status word that drifts from the configuration edges is visible one cycle after the offending configuration write, on a read of offset 0x24. An interrupt flop that disagrees with the ECC error word shows on `ecc_irq` in the cycle after the write that should have moved it.

// File: rtl/sdram_csr_pkg.sv
package sdram_csr_pkg;
  localparam int DW    = 32;
  localparam int OFS_W = 8;

  localparam logic [OFS_W-1:0] OFS_ERR0   = 8'h00;
  localparam logic [OFS_W-1:0] OFS_ERR1   = 8'h08;
  localparam logic [OFS_W-1:0] OFS_ERRADR = 8'h10;
  localparam logic [OFS_W-1:0] OFS_CFG    = 8'h20;
  localparam logic [OFS_W-1:0] OFS_STAT   = 8'h24;
  localparam logic [OFS_W-1:0] OFS_RTR    = 8'h30;
  localparam logic [OFS_W-1:0] OFS_PMIT   = 8'h34;
  localparam logic [OFS_W-1:0] OFS_BANK   = 8'h40;
  localparam logic [OFS_W-1:0] OFS_TR     = 8'h80;
  localparam logic [OFS_W-1:0] OFS_ECCCFG = 8'h94;
  localparam logic [OFS_W-1:0] OFS_ECCERR = 8'h98;

  localparam logic [DW-1:0] RTR_KEEP   = 32'h3FF8_0000;
  localparam logic [DW-1:0] PMIT_KEEP  = 32'hF800_0000;
  localparam logic [DW-1:0] PMIT_FORCE = 32'h07C0_0000;
  localparam logic [DW-1:0] TR_KEEP    = 32'h018F_C01F;
  localparam logic [DW-1:0] ECCCFG_KEEP= 32'h00F0_0000;
  localparam logic [DW-1:0] BANK_KEEP  = 32'hFFDE_E001;
  localparam logic [DW-1:0] STAT_RESET = 32'h8000_0000;

  localparam int EN_BIT = 31;
  localparam int SR_BIT = 30;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ERR0, SEL_ERR1, SEL_ERRADR, SEL_CFG, SEL_STAT,
    SEL_RTR, SEL_PMIT, SEL_BANK, SEL_TR, SEL_ECCCFG, SEL_ECCERR
  } csr_sel_e;

  function automatic logic [DW-1:0] f_rtr(input logic [DW-1:0] v);
    return v & RTR_KEEP;
  endfunction

  function automatic logic [DW-1:0] f_pmit(input logic [DW-1:0] v);
    return (v & PMIT_KEEP) | PMIT_FORCE;
  endfunction

  function automatic logic [DW-1:0] f_tr(input logic [DW-1:0] v);
    return v & TR_KEEP;
  endfunction

  function automatic logic [DW-1:0] f_ecccfg(input logic [DW-1:0] v);
    return v & ECCCFG_KEEP;
  endfunction

  function automatic logic [DW-1:0] f_bank(input logic [DW-1:0] v);
    return v & BANK_KEEP;
  endfunction

  function automatic logic f_bank_hit(input logic [OFS_W-1:0] o, input int nbank);
    int span;
    span = 4 * nbank;
    return (int'(o) >= int'(OFS_BANK)) && (int'(o) < int'(OFS_BANK) + span) && (o[1:0] == 2'b00);
  endfunction

  function automatic logic [OFS_W-1:0] f_bank_idx(input logic [OFS_W-1:0] o);
    logic [OFS_W-1:0] d;
    d = o - OFS_BANK;
    return d >> 2;
  endfunction

  function automatic csr_sel_e f_decode(input logic [OFS_W-1:0] o, input int nbank);
    if (f_bank_hit(o, nbank)) return SEL_BANK;
    case (o)
      OFS_ERR0:   return SEL_ERR0;
      OFS_ERR1:   return SEL_ERR1;
      OFS_ERRADR: return SEL_ERRADR;
      OFS_CFG:    return SEL_CFG;
      OFS_STAT:   return SEL_STAT;
      OFS_RTR:    return SEL_RTR;
      OFS_PMIT:   return SEL_PMIT;
      OFS_TR:     return SEL_TR;
      OFS_ECCCFG: return SEL_ECCCFG;
      OFS_ECCERR: return SEL_ECCERR;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sdram_csr_status.sv
module sdram_csr_status
  import sdram_csr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [DW-1:0] cfg_old,
  input  logic [DW-1:0] cfg_new,
  output logic [DW-1:0] status_q
);
  logic en_rise, en_fall, sr_edge;
  assign en_rise = cfg_wr && !cfg_old[EN_BIT] &&  cfg_new[EN_BIT];
  assign en_fall = cfg_wr &&  cfg_old[EN_BIT] && !cfg_new[EN_BIT];
  assign sr_edge = cfg_wr && (cfg_old[SR_BIT] != cfg_new[SR_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= STAT_RESET;
    end else begin
      if (en_rise) status_q[EN_BIT] <= 1'b0;
      if (en_fall) status_q[EN_BIT] <= 1'b1;
      if (sr_edge) status_q[SR_BIT] <= cfg_new[SR_BIT];
    end
  end

  AST_EN_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> !status_q[EN_BIT]);                                  // R3
  AST_EN_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> status_q[EN_BIT]);                                   // R3
  AST_SR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    sr_edge |=> status_q[SR_BIT] == $past(cfg_new[SR_BIT]));         // R4
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(status_q));                                  // R5
endmodule

// File: rtl/sdram_csr_ecc.sv
module sdram_csr_ecc
  import sdram_csr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_wr,
  input  logic [DW-1:0] err_wdata,
  output logic [DW-1:0] err_q,
  output logic          irq_q
);
  logic raise_ev, lower_ev;
  assign raise_ev = err_wr && (err_q == '0) && (err_wdata != '0);
  assign lower_ev = err_wr && (err_q != '0) && (err_wdata == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (err_wr)   err_q <= err_wdata;
      if (raise_ev) irq_q <= 1'b1;
      else if (lower_ev) irq_q <= 1'b0;
    end
  end

  AST_IRQ_TRACKS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (err_q != '0));                                         // R9
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    raise_ev |=> irq_q);                                             // R9
endmodule

// File: rtl/sdram_csr_banks.sv
module sdram_csr_banks
  import sdram_csr_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NBANK-1:0]          bank_we,
  input  logic [DW-1:0]             bank_wdata,
  output logic [NBANK-1:0][DW-1:0]  bank_q
);
  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bank_q[k] <= '0;
      else if (bank_we[k]) bank_q[k] <= f_bank(bank_wdata);
    end
  end

  AST_ONE_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));                                              // R8
endmodule

// File: rtl/sdram_csr_file.sv
module sdram_csr_file
  import sdram_csr_pkg::*;
#(
  parameter int IDX_W    = 10,
  parameter int PTR_IDX  = 16,
  parameter int DATA_IDX = 17,
  parameter int NBANK    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [31:0]      acc_wdata,
  output logic [31:0]      acc_rdata,
  output logic             ecc_irq
);
  localparam int BIW = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic hit_ptr, hit_data, wr_ptr, wr_data;
  assign hit_ptr  = acc_en && (acc_idx == IDX_W'(PTR_IDX));
  assign hit_data = acc_en && (acc_idx == IDX_W'(DATA_IDX));
  assign wr_ptr   = hit_ptr  && acc_wr;
  assign wr_data  = hit_data && acc_wr;

  logic [OFS_W-1:0] ptr_q;
  csr_sel_e         sel;
  logic [OFS_W-1:0] bank_idx_full;
  logic [BIW-1:0]   bank_idx;
  assign sel           = f_decode(ptr_q, NBANK);
  assign bank_idx_full = f_bank_idx(ptr_q);
  assign bank_idx      = bank_idx_full[BIW-1:0];

  logic [DW-1:0] err0_q, err1_q, erradr_q, cfg_q, rtr_q, pmit_q, tr_q, ecccfg_q;
  logic [DW-1:0] status_q, eccerr_q;
  logic [NBANK-1:0][DW-1:0] bank_q;
  logic [NBANK-1:0] bank_we;
  logic cfg_wr, eccerr_wr;

  assign cfg_wr    = wr_data && (sel == SEL_CFG);
  assign eccerr_wr = wr_data && (sel == SEL_ECCERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      err0_q   <= '0;
      err1_q   <= '0;
      erradr_q <= '0;
      cfg_q    <= '0;
      rtr_q    <= '0;
      pmit_q   <= PMIT_FORCE;
      tr_q     <= '0;
      ecccfg_q <= '0;
    end else begin
      if (wr_ptr) ptr_q <= acc_wdata[OFS_W-1:0];
      if (wr_data) begin
        case (sel)
          SEL_ERR0:   err0_q   <= acc_wdata;
          SEL_ERR1:   err1_q   <= acc_wdata;
          SEL_ERRADR: erradr_q <= acc_wdata;
          SEL_CFG:    cfg_q    <= acc_wdata;
          SEL_RTR:    rtr_q    <= f_rtr(acc_wdata);
          SEL_PMIT:   pmit_q   <= f_pmit(acc_wdata);
          SEL_TR:     tr_q     <= f_tr(acc_wdata);
          SEL_ECCCFG: ecccfg_q <= f_ecccfg(acc_wdata);
          default:    ;
        endcase
      end
    end
  end

  for (genvar k = 0; k < NBANK; k++) begin : g_we
    assign bank_we[k] = wr_data && (sel == SEL_BANK) && (bank_idx == BIW'(k));
  end

  sdram_csr_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_old  (cfg_q),
    .cfg_new  (acc_wdata),
    .status_q (status_q)
  );

  sdram_csr_ecc u_ecc (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_wr    (eccerr_wr),
    .err_wdata (acc_wdata),
    .err_q     (eccerr_q),
    .irq_q     (ecc_irq)
  );

  sdram_csr_banks #(.NBANK(NBANK)) u_banks (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_we    (bank_we),
    .bank_wdata (acc_wdata),
    .bank_q     (bank_q)
  );

  logic [DW-1:0] sel_val;
  always_comb begin
    case (sel)
      SEL_ERR0:   sel_val = err0_q;
      SEL_ERR1:   sel_val = err1_q;
      SEL_ERRADR: sel_val = erradr_q;
      SEL_CFG:    sel_val = cfg_q;
      SEL_STAT:   sel_val = status_q;
      SEL_RTR:    sel_val = rtr_q;
      SEL_PMIT:   sel_val = pmit_q;
      SEL_BANK:   sel_val = bank_q[bank_idx];
      SEL_TR:     sel_val = tr_q;
      SEL_ECCCFG: sel_val = ecccfg_q;
      SEL_ECCERR: sel_val = eccerr_q;
      default:    sel_val = '0;
    endcase
  end

  always_comb begin
    if (hit_ptr && !acc_wr)       acc_rdata = {{(DW-OFS_W){1'b0}}, ptr_q};
    else if (hit_data && !acc_wr) acc_rdata = sel_val;
    else                          acc_rdata = '0;
  end

  AST_STRAY_IDX_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !hit_ptr && !hit_data) |-> acc_rdata == '0);          // R1
  AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ptr |=> $stable(ptr_q));                                     // R1
  AST_PMIT_FORCED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && sel == SEL_PMIT) |=> pmit_q[26:22] == 5'h1F);        // R7
  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && sel == SEL_NONE) |=> $stable(cfg_q) && $stable(rtr_q)); // R10
endmodule

// File: tb/sdram_csr_file_bench.sv
module sdram_csr_file_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] PTR  = 10'h010;
  localparam logic [9:0] DATA = 10'h011;

  logic clk = 1'b0, rst_n = 1'b0, acc_en = 1'b0, acc_wr = 1'b0;
  logic [9:0]  acc_idx = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        ecc_irq;
  int nchk = 0, nfail = 0;
  bit done = 0;

  sdram_csr_file u_sdram_csr_file (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .ecc_irq(ecc_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed { logic [7:0] ofs; logic [31:0] wd; logic [31:0] exp; } vec_t;
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R11
    '{8'h08, 32'h1234_5678, 32'h1234_5678},  // R11
    '{8'h10, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R11
    '{8'h20, 32'h0123_4567, 32'h0123_4567},  // R11
    '{8'h30, 32'hFFFF_FFFF, 32'h3FF8_0000},  // R6
    '{8'h30, 32'h1234_5678, 32'h1230_0000},  // R6
    '{8'h80, 32'hFFFF_FFFF, 32'h018F_C01F},  // R6
    '{8'h80, 32'h1234_5678, 32'h0004_4018},  // R6
    '{8'h94, 32'hFFFF_FFFF, 32'h00F0_0000},  // R6
    '{8'h34, 32'h0000_0000, 32'h07C0_0000},  // R7
    '{8'h34, 32'hFFFF_FFFF, 32'hFFC0_0000},  // R7
    '{8'h40, 32'hFFFF_FFFF, 32'hFFDE_E001},  // R8
    '{8'h44, 32'h1234_5678, 32'h1214_4000},  // R8
    '{8'h48, 32'hAAAA_AAAA, 32'hAA8A_A000},  // R8
    '{8'h4C, 32'h5555_5555, 32'h5554_4001},  // R8
    '{8'h04, 32'hFFFF_FFFF, 32'h0000_0000}   // R10
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic dcr_wr(input logic [9:0] idx, input logic [31:0] v);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_idx = idx; acc_wdata = v;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic dcr_rd(input logic [9:0] idx, output logic [31:0] v);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_idx = idx;
    #1 v = acc_rdata;
    acc_en = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] o, input logic [31:0] v);
    dcr_wr(PTR, {24'h0, o});
    dcr_wr(DATA, v);
  endtask

  task automatic reg_rd(input logic [7:0] o, output logic [31:0] v);
    dcr_wr(PTR, {24'h0, o});
    dcr_rd(DATA, v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    dcr_rd(PTR, r);      check("R2 pointer reset", r, 32'h0);
    dcr_rd(DATA, r);     check("R2 error status 0 reset", r, 32'h0);
    check("R2 irq reset", {31'h0, ecc_irq}, 32'h0);
    reg_rd(8'h24, r);    check("R2 status reset", r, 32'h8000_0000);
    reg_rd(8'h34, r);    check("R2 pm timer reset", r, 32'h07C0_0000);
    reg_rd(8'h94, r);    check("R2 ecc cfg reset", r, 32'h0);
    reg_rd(8'h98, r);    check("R2 ecc err reset", r, 32'h0);
    reg_rd(8'h4C, r);    check("R2 bank 3 reset", r, 32'h0);

    // table walk: R6 R7 R8 R10 R11
    for (int i = 0; i < NV; i++) begin
      reg_wr(VEC[i].ofs, VEC[i].wd);
      reg_rd(VEC[i].ofs, r);
      check($sformatf("table %0d ofs %h (R6 R7 R8 R10 R11)", i, VEC[i].ofs), r, VEC[i].exp);
    end
    // R8 earlier bank untouched by later bank writes
    reg_rd(8'h40, r);    check("R8 bank 0 kept", r, 32'hFFDE_E001);
    reg_rd(8'h44, r);    check("R8 bank 1 kept", r, 32'h1214_4000);
    // R10 unaligned bank-range offset is unmapped
    reg_wr(8'h42, 32'hFFFF_FFFF);
    reg_rd(8'h42, r);    check("R10 unaligned read zero", r, 32'h0);
    reg_rd(8'h40, r);    check("R10 unaligned write no effect", r, 32'hFFDE_E001);

    // R1 pointer keeps low 8 bits only
    dcr_wr(PTR, 32'hFFFF_FF94);
    dcr_rd(PTR, r);      check("R1 pointer truncation", r, 32'h94);
    dcr_rd(DATA, r);     check("R1 data via truncated pointer", r, 32'h00F0_0000);
    // R1 foreign index: read zero, write ignored
    dcr_wr(10'h012, 32'h30);
    dcr_rd(PTR, r);      check("R1 foreign index write ignored", r, 32'h94);
    dcr_rd(10'h012, r);  check("R1 foreign index reads zero", r, 32'h0);

    // R3 R4 configuration edges
    reg_wr(8'h20, 32'h0000_0000);
    reg_rd(8'h24, r);    check("R3 status with enable low", r, 32'h8000_0000);
    reg_wr(8'h20, 32'h8000_0000);
    reg_rd(8'h24, r);    check("R3 enable rise clears", r, 32'h0000_0000);
    reg_wr(8'h20, 32'hC000_0000);
    reg_rd(8'h24, r);    check("R4 bit 30 rise copied", r, 32'h4000_0000);
    reg_wr(8'h20, 32'h0000_0000);
    reg_rd(8'h24, r);    check("R3 R4 both fall", r, 32'h8000_0000);
    reg_wr(8'h20, 32'h4000_0000);
    reg_rd(8'h24, r);    check("R4 bit 30 alone", r, 32'hC000_0000);

    // R5 status read-only
    reg_wr(8'h24, 32'h0000_0000);
    reg_rd(8'h24, r);    check("R5 status write ignored", r, 32'hC000_0000);
    reg_wr(8'h24, 32'hFFFF_FFFF);
    reg_rd(8'h24, r);    check("R5 status write ones ignored", r, 32'hC000_0000);

    // R9 ECC error and interrupt
    reg_wr(8'h98, 32'h0000_0005);
    check("R9 irq raised", {31'h0, ecc_irq}, 32'h1);
    reg_wr(8'h98, 32'h0000_0007);
    check("R9 irq held on nonzero rewrite", {31'h0, ecc_irq}, 32'h1);
    reg_rd(8'h98, r);    check("R9 ecc err value", r, 32'h0000_0007);
    reg_wr(8'h98, 32'h0000_0000);
    check("R9 irq lowered", {31'h0, ecc_irq}, 32'h0);
    reg_wr(8'h98, 32'h0000_0000);
    check("R9 irq stays low on zero rewrite", {31'h0, ecc_irq}, 32'h0);

    finish_run();
  end
endmodule